// File: doc/BRIEF.md
# Address-Triggered Auto-Store Controller

This block decides when a capture path starts and stops storing incoming blocks. Data blocks and audio blocks use the same trigger. Each decoded block address arrives with a valid strobe and an error flag. The address has three fields: minute, second and frame. While the controller is enabled and armed, it watches each strobed address. Storing starts when all three fields match the programmed start fields exactly and the error flag is clear.

After it starts, the controller counts the following block strobes against a stop count. The stop count is taken at the moment of the match. When that count runs out, the controller drops its store-active output and pulses a done output for one cycle. Clearing the enable bit abandons an armed or running capture without a done pulse. After a capture completes, a new one needs the enable bit to be cleared and set again.

The controller does not decode headers, correct errors or write to the buffer memory.

Top module: `addr_autostore`

## Requirements
- R1: During and after reset the controller is idle, with `store_active` low and `store_done` low.
- R2: While armed, an `addr_valid` strobe that has `addr_err` low and whose three 8-bit fields (minute, second, frame) each equal the matching start field, compared as raw bytes, starts storing. `store_active` is high from the next cycle on.
- R3: A strobe in which any single bit of any one field differs from the start value does not start storing, and the controller stays armed.
- R4: A matching strobe with `addr_err` high does not start storing, and the controller stays armed.
- R5: Matching field values with `addr_valid` low never start storing.
- R6: `stop_cnt_load` is sampled at the matching strobe as a count N greater than 0. While storing, each later `addr_valid` strobe uses up one count, and cycles without a strobe use up none. In the cycle after the N-th strobe, `store_active` falls and `store_done` is high for exactly one cycle.
- R7: While storing, strobes with `addr_err` high do not abort the capture, and each one still uses up a count.
- R8: With `stop_cnt_load` equal to zero, a matching strobe leaves `store_active` low and raises `store_done` for one cycle in the next cycle.
- R9: With `en` low, the next cycle has `store_active` low and `store_done` low, even while armed or storing. The controller returns to idle.
- R10: After a completed capture, the controller ignores matching strobes for as long as `en` stays high. It re-arms only after `en` has been low.
- R11: In idle, the controller arms one cycle after it samples `en` high. A matching strobe in that first cycle does not start storing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Auto-store enable |
| addr_valid | input | 1 | Strobe: one decoded block address is present |
| addr_err | input | 1 | The strobed address is flagged as erroneous |
| cur_min | input | FIELD_W | Decoded minute field |
| cur_sec | input | FIELD_W | Decoded second field |
| cur_frm | input | FIELD_W | Decoded frame field |
| start_min | input | FIELD_W | Programmed start minute |
| start_sec | input | FIELD_W | Programmed start second |
| start_frm | input | FIELD_W | Programmed start frame |
| stop_cnt_load | input | CNT_W | Number of blocks to store after the match |
| store_active | output | 1 | High while storing |
| store_done | output | 1 | One-cycle pulse when a capture completes |

## Verification
The bench builds the block with `CNT_W = 4` and keeps 8-bit fields. With that width, every possible stop count from 0 to 15 gets a full start-to-done run. Each run mixes idle gaps and error-flagged strobes into the count-down. With 8-bit fields, a single-bit flip can be tried in each of the 24 address bit positions to show that a near-match never triggers. Separate scenarios cover:
- aborting while armed and while storing;
- a strobe that arrives in the same cycle as the enable;
- the lockout after a completed capture.

// File: rtl/autostore_pkg.sv
package autostore_pkg;

    typedef enum logic [1:0] {
        AS_IDLE  = 2'd0,
        AS_ARMED = 2'd1,
        AS_STORE = 2'd2,
        AS_SPENT = 2'd3
    } as_state_e;

    localparam int unsigned AS_NUM_FIELDS = 3;

endpackage

// File: rtl/as_addr_match.sv
module as_addr_match #(
    parameter int unsigned FIELD_W    = 8,
    parameter int unsigned NUM_FIELDS = 3
) (
    input  logic [NUM_FIELDS*FIELD_W-1:0] cur_flat,
    input  logic [NUM_FIELDS*FIELD_W-1:0] start_flat,
    output logic                          hit
);

    logic [NUM_FIELDS-1:0] field_eq;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        assign field_eq[g] = (cur_flat[g*FIELD_W +: FIELD_W] == start_flat[g*FIELD_W +: FIELD_W]);
    end

    assign hit = &field_eq;

endmodule

// File: rtl/as_block_counter.sv
module as_block_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == ONE);

    // R6: a decrement is never requested from an empty counter
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));

endmodule

// File: rtl/addr_autostore.sv
module addr_autostore
    import autostore_pkg::*;
#(
    parameter int unsigned FIELD_W = 8,
    parameter int unsigned CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               addr_valid,
    input  logic               addr_err,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] cur_frm,
    input  logic [FIELD_W-1:0] start_min,
    input  logic [FIELD_W-1:0] start_sec,
    input  logic [FIELD_W-1:0] start_frm,
    input  logic [CNT_W-1:0]   stop_cnt_load,
    output logic               store_active,
    output logic               store_done
);

    localparam int unsigned ADDR_W = AS_NUM_FIELDS * FIELD_W;

    typedef struct packed {
        as_state_e state;
        logic      done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              addr_hit;
    logic              start_hit;
    logic              load_zero;
    logic              cnt_load;
    logic              cnt_dec;
    logic              cnt_last;
    logic [ADDR_W-1:0] cur_flat;
    logic [ADDR_W-1:0] start_flat;

    assign cur_flat   = {cur_min, cur_sec, cur_frm};
    assign start_flat = {start_min, start_sec, start_frm};

    as_addr_match #(
        .FIELD_W    (FIELD_W),
        .NUM_FIELDS (AS_NUM_FIELDS)
    ) match_i (
        .cur_flat   (cur_flat),
        .start_flat (start_flat),
        .hit        (addr_hit)
    );

    as_block_counter #(
        .CNT_W (CNT_W)
    ) count_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (stop_cnt_load),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    assign start_hit = addr_valid && !addr_err && addr_hit;
    assign load_zero = (stop_cnt_load == '0);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        cnt_load   = 1'b0;
        cnt_dec    = 1'b0;
        unique case (ctl_q.state)
            AS_IDLE: begin
                if (en) ctl_d.state = AS_ARMED;
            end
            AS_ARMED: begin
                if (!en) begin
                    ctl_d.state = AS_IDLE;
                end else if (start_hit) begin
                    if (load_zero) begin
                        ctl_d.state = AS_SPENT;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.state = AS_STORE;
                        cnt_load    = 1'b1;
                    end
                end
            end
            AS_STORE: begin
                if (!en) begin
                    ctl_d.state = AS_IDLE;
                end else if (addr_valid) begin
                    cnt_dec = 1'b1;
                    if (cnt_last) begin
                        ctl_d.state = AS_SPENT;
                        ctl_d.done  = 1'b1;
                    end
                end
            end
            AS_SPENT: begin
                if (!en) ctl_d.state = AS_IDLE;
            end
            default: ctl_d.state = AS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: AS_IDLE, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign store_active = (ctl_q.state == AS_STORE);
    assign store_done   = ctl_q.done;

    // R6: the done pulse lasts exactly one cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        store_done |=> !store_done);

    // R6: done never coincides with an active capture
    assert_done_not_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        store_done |-> !store_active);

    // R9: a low enable clears activity and suppresses done in the next cycle
    assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!store_active && !store_done));

    // R4: an erroneous strobe seen while armed cannot start a capture
    assert_err_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == AS_ARMED && addr_valid && addr_err) |=> (!store_active && !store_done));

    // R10: after completion nothing restarts while enable stays high
    assert_spent_lockout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == AS_SPENT) |=> (!store_active && !store_done));

    // R11: idle never jumps straight into storing
    assert_idle_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == AS_IDLE) |=> !store_active);

endmodule

// File: tb/addr_autostore_tb.sv
`timescale 1ns/1ps
module addr_autostore_tb_top;

    localparam int unsigned FW = 8;
    localparam int unsigned CW = 4;
    localparam logic [FW-1:0] SM = 8'h12;
    localparam logic [FW-1:0] SS = 8'h34;
    localparam logic [FW-1:0] SF = 8'h56;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          addr_valid = 1'b0;
    logic          addr_err = 1'b0;
    logic [FW-1:0] cur_min = '0, cur_sec = '0, cur_frm = '0;
    logic [CW-1:0] stop_cnt_load = '0;
    logic          store_active, store_done;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    addr_autostore #(.FIELD_W(FW), .CNT_W(CW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .addr_valid    (addr_valid),
        .addr_err      (addr_err),
        .cur_min       (cur_min),
        .cur_sec       (cur_sec),
        .cur_frm       (cur_frm),
        .start_min     (SM),
        .start_sec     (SS),
        .start_frm     (SF),
        .stop_cnt_load (stop_cnt_load),
        .store_active  (store_active),
        .store_done    (store_done)
    );

    task automatic chk(input string req, input string what, input logic act_a, input logic act_d,
                       input logic exp_a, input logic exp_d);
        n_checks++;
        if (act_a !== exp_a || act_d !== exp_d) begin
            n_fails++;
            $display("FAIL %s %s: active/done actual %b/%b expected %b/%b",
                     req, what, act_a, act_d, exp_a, exp_d);
        end
    endtask

    // Return to idle, then enable; leaves the controller armed at a falling edge
    task automatic rearm();
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe(input logic [FW-1:0] m, input logic [FW-1:0] s,
                          input logic [FW-1:0] f, input logic err);
        cur_min = m; cur_sec = s; cur_frm = f;
        addr_valid = 1'b1; addr_err = err;
        @(negedge clk);
        addr_valid = 1'b0; addr_err = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "in reset", store_active, store_done, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "after reset", store_active, store_done, 1'b0, 1'b0);

        // R2 R6 R7 R8: sweep every stop count
        for (int n = 0; n < (1 << CW); n++) begin
            rearm();
            stop_cnt_load = CW'(n);
            strobe(SM, SS, SF, 1'b0);
            stop_cnt_load = CW'((n + 7) % (1 << CW));
            if (n == 0) begin
                chk("R8", "zero count match", store_active, store_done, 1'b0, 1'b1);
                @(negedge clk);
                chk("R8", "zero count done width", store_active, store_done, 1'b0, 1'b0);
            end else begin
                chk("R2", "start on match", store_active, store_done, 1'b1, 1'b0);
                for (int k = 1; k <= n; k++) begin
                    if (k % 3 == 0) begin
                        @(negedge clk);
                        chk("R6", "gap holds", store_active, store_done, 1'b1, 1'b0);
                    end
                    strobe(8'(k), 8'h00, 8'(k * 5), (k % 2) == 1);
                    if (k < n)
                        chk("R7", "counting", store_active, store_done, 1'b1, 1'b0);
                    else
                        chk("R6", "stop after N", store_active, store_done, 1'b0, 1'b1);
                end
                @(negedge clk);
                chk("R6", "done one cycle", store_active, store_done, 1'b0, 1'b0);
            end
        end

        // R10: completed, enable still high
        strobe(SM, SS, SF, 1'b0);
        chk("R10", "no restart while spent", store_active, store_done, 1'b0, 1'b0);
        @(negedge clk);
        chk("R10", "still idle", store_active, store_done, 1'b0, 1'b0);

        // R3: single-bit flips in every field position
        stop_cnt_load = CW'(3);
        rearm();
        for (int fld = 0; fld < 3; fld++) begin
            for (int b = 0; b < FW; b++) begin
                strobe((fld == 0) ? (SM ^ (8'h1 << b)) : SM,
                       (fld == 1) ? (SS ^ (8'h1 << b)) : SS,
                       (fld == 2) ? (SF ^ (8'h1 << b)) : SF, 1'b0);
                chk("R3", "near miss", store_active, store_done, 1'b0, 1'b0);
            end
        end
        strobe(SM, SS, SF, 1'b0);
        chk("R3", "still armed after misses", store_active, store_done, 1'b1, 1'b0);

        // R4: error-flagged match
        rearm();
        strobe(SM, SS, SF, 1'b1);
        chk("R4", "errored match", store_active, store_done, 1'b0, 1'b0);
        strobe(SM, SS, SF, 1'b0);
        chk("R4", "armed after error", store_active, store_done, 1'b1, 1'b0);

        // R5: matching fields without the strobe
        rearm();
        cur_min = SM; cur_sec = SS; cur_frm = SF;
        repeat (4) @(negedge clk);
        chk("R5", "no strobe", store_active, store_done, 1'b0, 1'b0);

        // R9: abort while storing
        rearm();
        stop_cnt_load = CW'(5);
        strobe(SM, SS, SF, 1'b0);
        strobe(8'h01, 8'h01, 8'h01, 1'b0);
        chk("R9", "storing before abort", store_active, store_done, 1'b1, 1'b0);
        en = 1'b0;
        strobe(8'h02, 8'h02, 8'h02, 1'b0);
        chk("R9", "abort while storing", store_active, store_done, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R9", "no late done", store_active, store_done, 1'b0, 1'b0);

        // R9: abort while armed, match arrives with enable low
        rearm();
        en = 1'b0;
        strobe(SM, SS, SF, 1'b0);
        chk("R9", "abort while armed", store_active, store_done, 1'b0, 1'b0);

        // R11: strobe in the very cycle enable rises
        @(negedge clk);
        en = 1'b1;
        strobe(SM, SS, SF, 1'b0);
        chk("R11", "same-cycle strobe ignored", store_active, store_done, 1'b0, 1'b0);
        strobe(SM, SS, SF, 1'b0);
        chk("R11", "starts once armed", store_active, store_done, 1'b1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule